// File: doc/BRIEF.md
# Processor Mode and Status Register

This block keeps the processor's eight-bit status word, the hidden emulation bit, the upper bytes of the two index registers and the full stack pointer. The execution pipeline issues one command per clock: set or clear a single flag, set or clear a group of status bits under a mask, load the whole status word from a value pulled off the stack, or swap the carry bit with the emulation bit. It also loads an index high byte or copies the X register into the stack pointer.

Emulation mode locks part of the machine state. While the emulation bit is 1, the accumulator and index width bits stay at 1. The index high bytes stay at zero, and the stack pointer stays in page one. Swapping carry with the emulation bit is the only way to move between modes. The block applies the locks in the same update as the command, so the pipeline never sees a forbidden combination.

All outputs come from registers. The two width flags tell the datapath whether the accumulator and the index registers are 16 bits wide.

Top module: `cpu_mode_status`

## Requirements
- R1: A synchronous active-high reset sets the status word to 0x34 (width bits and interrupt-disable set, every other bit clear, decimal clear). It sets emulation to 1, both index high bytes to 0 and the stack pointer to {0x01, SP_RST_LO}, which is 0x01FF by default.
- R2: Status bit positions are C=0, Z=1, I=2, D=3, X=4, M=5, V=6, N=7. Commands 1..6 clear or set C, D and I in the order clear C, set C, clear D, set D, clear I, set I, and change no other bit. Command 7 clears V and nothing else.
- R3: Command 9 (mask set) sets every status bit whose `arg` bit is 1 and leaves the others unchanged.
- R4: Command 8 (mask clear) clears every status bit whose `arg` bit is 1. While emulation is 1, M and X stay at 1.
- R5: Command 10 (pull) loads all eight status bits from `arg`. While emulation is 1, M and X stay at 1.
- R6: Command 11 swaps the carry bit and the emulation bit in a single update.
- R7: Whenever emulation is 1, M=1, X=1, both index high bytes are 0 and the stack pointer high byte is 0x01. This also holds in the update that enters emulation.
- R8: Command 12 loads the stack pointer from `xfer_val`. With emulation 1 it takes only the low byte and forces the high byte to 0x01. With emulation 0 it takes all 16 bits, whatever M and X are.
- R9: Commands 13 and 14 load the X and Y high bytes from `arg` only while X=0, and are ignored otherwise. Any update that leaves X at 1 clears both high bytes in that same update.
- R10: `m_wide` equals the inverse of M and `x_wide` equals the inverse of X at every clock after reset.
- R11: Every result shows on the outputs one clock after the command is sampled. With `cmd_valid` low, or with command 0 or 15, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present this cycle |
| cmd | input | 4 | Command code |
| arg | input | BYTE_W | Mask, pulled status value or index high byte |
| xfer_val | input | 2*BYTE_W | X register value for the stack pointer transfer |
| p_out | output | 8 | Status word |
| e_out | output | 1 | Emulation bit |
| m_wide | output | 1 | Accumulator is 16 bits |
| x_wide | output | 1 | Index registers are 16 bits |
| x_hi | output | BYTE_W | X register high byte |
| y_hi | output | BYTE_W | Y register high byte |
| sp_out | output | 2*BYTE_W | Stack pointer |

## Verification
Every result of this block is due exactly one rising edge after its command is sampled. This covers the flag changes, the mode swap, the lock forcing, the index clear and the stack pointer load. Nothing is spread over more cycles.

The bench drives each command on a falling edge and advances its reference model by one step at the same moment. On the next falling edge it compares every output against the model, so the comparison always falls half a period after the edge that was meant to produce the change. Idle cycles and a long pseudo-random command stream are compared the same way, cycle by cycle.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
  localparam int CMD_W  = 4;
  localparam int STAT_W = 8;

  localparam int BIT_C = 0;
  localparam int BIT_Z = 1;
  localparam int BIT_I = 2;
  localparam int BIT_D = 3;
  localparam int BIT_X = 4;
  localparam int BIT_M = 5;
  localparam int BIT_V = 6;
  localparam int BIT_N = 7;

  localparam logic [STAT_W-1:0] WIDTH_LOCK = (8'h1 << BIT_M) | (8'h1 << BIT_X);
  localparam logic [STAT_W-1:0] P_RESET    = WIDTH_LOCK | (8'h1 << BIT_I);

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP       = 4'd0,
    CMD_CLR_C     = 4'd1,
    CMD_SET_C     = 4'd2,
    CMD_CLR_D     = 4'd3,
    CMD_SET_D     = 4'd4,
    CMD_CLR_I     = 4'd5,
    CMD_SET_I     = 4'd6,
    CMD_CLR_V     = 4'd7,
    CMD_MASK_CLR  = 4'd8,
    CMD_MASK_SET  = 4'd9,
    CMD_PULL      = 4'd10,
    CMD_SWAP_CE   = 4'd11,
    CMD_SP_FROM_X = 4'd12,
    CMD_LD_XHI    = 4'd13,
    CMD_LD_YHI    = 4'd14,
    CMD_RSVD      = 4'd15
  } mode_cmd_e;
endpackage

// File: rtl/pstat_flag_next.sv
module pstat_flag_next
  import pmode_pkg::*;
(
  input  logic [STAT_W-1:0] p_cur,
  input  logic              e_cur,
  input  logic              cmd_valid,
  input  mode_cmd_e         cmd,
  input  logic [STAT_W-1:0] mask,
  output logic [STAT_W-1:0] p_nxt,
  output logic              e_nxt
);
  logic [STAT_W-1:0] p_raw;

  always_comb begin
    p_raw = p_cur;
    e_nxt = e_cur;
    if (cmd_valid) begin
      unique case (cmd)
        CMD_CLR_C:    p_raw[BIT_C] = 1'b0;
        CMD_SET_C:    p_raw[BIT_C] = 1'b1;
        CMD_CLR_D:    p_raw[BIT_D] = 1'b0;
        CMD_SET_D:    p_raw[BIT_D] = 1'b1;
        CMD_CLR_I:    p_raw[BIT_I] = 1'b0;
        CMD_SET_I:    p_raw[BIT_I] = 1'b1;
        CMD_CLR_V:    p_raw[BIT_V] = 1'b0;
        CMD_MASK_CLR: p_raw = p_cur & ~mask;
        CMD_MASK_SET: p_raw = p_cur | mask;
        CMD_PULL:     p_raw = mask;
        CMD_SWAP_CE: begin
          p_raw[BIT_C] = e_cur;
          e_nxt        = p_cur[BIT_C];
        end
        default: p_raw = p_cur;
      endcase
    end
    p_nxt = e_nxt ? (p_raw | WIDTH_LOCK) : p_raw;
  end
endmodule

// File: rtl/pstat_index_hi.sv
module pstat_index_hi #(
  parameter int BYTE_W = 8,
  parameter int N_IDX  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_IDX-1:0]        ld,
  input  logic [BYTE_W-1:0]       din,
  input  logic                    narrow_nxt,
  output logic [N_IDX*BYTE_W-1:0] hi_flat
);
  for (genvar g = 0; g < N_IDX; g++) begin : g_idx
    logic [BYTE_W-1:0] hi_q;
    always_ff @(posedge clk) begin
      if (rst)             hi_q <= '0;
      else if (narrow_nxt) hi_q <= '0;
      else if (ld[g])      hi_q <= din;
    end
    assign hi_flat[g*BYTE_W +: BYTE_W] = hi_q;
  end
endmodule

// File: rtl/pstat_stack_ptr.sv
module pstat_stack_ptr #(
  parameter int               BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] SP_RST_LO = 8'hFF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                emu_nxt,
  input  logic [2*BYTE_W-1:0] xfer,
  output logic [2*BYTE_W-1:0] sp
);
  localparam logic [BYTE_W-1:0] EMU_PAGE = BYTE_W'(1);

  logic [BYTE_W-1:0] sp_hi, sp_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_hi <= EMU_PAGE;
      sp_lo <= SP_RST_LO;
    end else begin
      if (load) sp_lo <= xfer[BYTE_W-1:0];
      if (emu_nxt)   sp_hi <= EMU_PAGE;
      else if (load) sp_hi <= xfer[2*BYTE_W-1:BYTE_W];
    end
  end

  assign sp = {sp_hi, sp_lo};
endmodule

// File: rtl/cpu_mode_status.sv
module cpu_mode_status
  import pmode_pkg::*;
#(
  parameter int               BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] SP_RST_LO = 8'hFF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [3:0]          cmd,
  input  logic [BYTE_W-1:0]   arg,
  input  logic [2*BYTE_W-1:0] xfer_val,
  output logic [7:0]          p_out,
  output logic                e_out,
  output logic                m_wide,
  output logic                x_wide,
  output logic [BYTE_W-1:0]   x_hi,
  output logic [BYTE_W-1:0]   y_hi,
  output logic [2*BYTE_W-1:0] sp_out
);
  localparam int N_IDX = 2;

  mode_cmd_e             cmd_e;
  logic [STAT_W-1:0]     p_q, p_nxt;
  logic                  e_q, e_nxt;
  logic                  mw_q, xw_q;
  logic [N_IDX-1:0]      idx_ld;
  logic [N_IDX*BYTE_W-1:0] idx_flat;
  logic                  sp_ld;

  assign cmd_e = mode_cmd_e'(cmd);

  pstat_flag_next u_flags (
    .p_cur     (p_q),
    .e_cur     (e_q),
    .cmd_valid (cmd_valid),
    .cmd       (cmd_e),
    .mask      (arg[STAT_W-1:0]),
    .p_nxt     (p_nxt),
    .e_nxt     (e_nxt)
  );

  assign idx_ld[0] = cmd_valid && (cmd_e == CMD_LD_XHI);
  assign idx_ld[1] = cmd_valid && (cmd_e == CMD_LD_YHI);
  assign sp_ld     = cmd_valid && (cmd_e == CMD_SP_FROM_X);

  pstat_index_hi #(.BYTE_W(BYTE_W), .N_IDX(N_IDX)) u_idx (
    .clk        (clk),
    .rst        (rst),
    .ld         (idx_ld),
    .din        (arg),
    .narrow_nxt (p_nxt[BIT_X]),
    .hi_flat    (idx_flat)
  );

  pstat_stack_ptr #(.BYTE_W(BYTE_W), .SP_RST_LO(SP_RST_LO)) u_sp (
    .clk     (clk),
    .rst     (rst),
    .load    (sp_ld),
    .emu_nxt (e_nxt),
    .xfer    (xfer_val),
    .sp      (sp_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q  <= P_RESET;
      e_q  <= 1'b1;
      mw_q <= 1'b0;
      xw_q <= 1'b0;
    end else begin
      p_q  <= p_nxt;
      e_q  <= e_nxt;
      mw_q <= ~p_nxt[BIT_M];
      xw_q <= ~p_nxt[BIT_X];
    end
  end

  assign p_out  = p_q;
  assign e_out  = e_q;
  assign m_wide = mw_q;
  assign x_wide = xw_q;
  assign x_hi   = idx_flat[BYTE_W-1:0];
  assign y_hi   = idx_flat[2*BYTE_W-1:BYTE_W];
endmodule

// File: rtl/cpu_mode_status_chk.sv
module cpu_mode_status_chk
  import pmode_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_valid,
  input logic [3:0]          cmd,
  input logic [BYTE_W-1:0]   arg,
  input logic [2*BYTE_W-1:0] xfer_val,
  input logic [7:0]          p_out,
  input logic                e_out,
  input logic                m_wide,
  input logic                x_wide,
  input logic [BYTE_W-1:0]   x_hi,
  input logic [BYTE_W-1:0]   y_hi,
  input logic [2*BYTE_W-1:0] sp_out
);
  localparam logic [BYTE_W-1:0] PAGE1 = BYTE_W'(1);

  a_r7_emul_lock: assert property (@(posedge clk) disable iff (rst)
    e_out |-> (p_out[BIT_M] && p_out[BIT_X] && x_hi == '0 && y_hi == '0 &&
               sp_out[2*BYTE_W-1:BYTE_W] == PAGE1));

  a_r6_swap: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == CMD_SWAP_CE) |=>
      (e_out == $past(p_out[BIT_C]) && p_out[BIT_C] == $past(e_out)));

  a_r3_mask_set: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == CMD_MASK_SET) |=> ((p_out & $past(arg[7:0])) == $past(arg[7:0])));

  a_r4_mask_clr: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == CMD_MASK_CLR) |=> ((p_out & $past(arg[7:0]) & 8'hCF) == 8'h00));

  a_r5_pull: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == CMD_PULL) |=> ((p_out & 8'hCF) == ($past(arg[7:0]) & 8'hCF)));

  a_r8_sp_native: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == CMD_SP_FROM_X && !e_out) |=> (sp_out == $past(xfer_val)));

  a_r9_narrow_clears: assert property (@(posedge clk) disable iff (rst)
    p_out[BIT_X] |-> (x_hi == '0 && y_hi == '0));

  a_r10_widths: assert property (@(posedge clk) disable iff (rst)
    (m_wide == !p_out[BIT_M]) && (x_wide == !p_out[BIT_X]));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ($stable(p_out) && $stable(e_out) && $stable(sp_out) &&
                    $stable(x_hi) && $stable(y_hi)));
endmodule

bind cpu_mode_status cpu_mode_status_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .arg(arg),
  .xfer_val(xfer_val), .p_out(p_out), .e_out(e_out), .m_wide(m_wide),
  .x_wide(x_wide), .x_hi(x_hi), .y_hi(y_hi), .sp_out(sp_out)
);

// File: tb/sim_cpu_mode_status.sv
module sim_cpu_mode_status;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd = 4'd0;
  logic [7:0]  arg = 8'd0;
  logic [15:0] xfer_val = 16'd0;
  logic [7:0]  p_out;
  logic        e_out, m_wide, x_wide;
  logic [7:0]  x_hi, y_hi;
  logic [15:0] sp_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  m_p;
  logic        m_e;
  logic [7:0]  m_xh, m_yh;
  logic [15:0] m_sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_mode_status u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .arg(arg),
    .xfer_val(xfer_val), .p_out(p_out), .e_out(e_out), .m_wide(m_wide),
    .x_wide(x_wide), .x_hi(x_hi), .y_hi(y_hi), .sp_out(sp_out)
  );

  task automatic compare(input string tag);
    logic [57:0] act, exp;
    act = {p_out, e_out, m_wide, x_wide, x_hi, y_hi, sp_out, 15'd0};
    exp = {m_p, m_e, ~m_p[5], ~m_p[4], m_xh, m_yh, m_sp, 15'd0};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: p=%h e=%b mw=%b xw=%b xh=%h yh=%h sp=%h expected p=%h e=%b mw=%b xw=%b xh=%h yh=%h sp=%h",
               tag, p_out, e_out, m_wide, x_wide, x_hi, y_hi, sp_out,
               m_p, m_e, ~m_p[5], ~m_p[4], m_xh, m_yh, m_sp);
    end
  endtask

  task automatic model_step(input logic v, input logic [3:0] c, input logic [7:0] a,
                            input logic [15:0] xv);
    logic t;
    if (v) begin
      case (c)
        4'd1:  m_p[0] = 1'b0;
        4'd2:  m_p[0] = 1'b1;
        4'd3:  m_p[3] = 1'b0;
        4'd4:  m_p[3] = 1'b1;
        4'd5:  m_p[2] = 1'b0;
        4'd6:  m_p[2] = 1'b1;
        4'd7:  m_p[6] = 1'b0;
        4'd8:  m_p = m_p & ~a;
        4'd9:  m_p = m_p | a;
        4'd10: m_p = a;
        4'd11: begin t = m_p[0]; m_p[0] = m_e; m_e = t; end
        4'd12: m_sp = m_e ? {8'h01, xv[7:0]} : xv;
        4'd13: if (!m_p[4]) m_xh = a;
        4'd14: if (!m_p[4]) m_yh = a;
        default: ;
      endcase
    end
    if (m_e) begin
      m_p[5] = 1'b1;
      m_p[4] = 1'b1;
      m_sp[15:8] = 8'h01;
    end
    if (m_p[4]) begin
      m_xh = 8'h00;
      m_yh = 8'h00;
    end
  endtask

  task automatic step(input logic v, input logic [3:0] c, input logic [7:0] a,
                      input logic [15:0] xv, input string tag);
    cmd_valid = v; cmd = c; arg = a; xfer_val = xv;
    model_step(v, c, a, xv);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    m_p = 8'h34; m_e = 1'b1; m_xh = 8'h00; m_yh = 8'h00; m_sp = 16'h01FF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1 reset state");

    step(1, 4'd2, 8'h00, 16'h0, "R2 set C");
    step(1, 4'd4, 8'h00, 16'h0, "R2 set D");
    step(1, 4'd5, 8'h00, 16'h0, "R2 clear I");
    step(1, 4'd9, 8'h40, 16'h0, "R3 mask set V");
    step(1, 4'd7, 8'h00, 16'h0, "R2 clear V only");
    step(1, 4'd1, 8'h00, 16'h0, "R2 clear C");
    step(1, 4'd3, 8'h00, 16'h0, "R2 clear D");
    step(1, 4'd6, 8'h00, 16'h0, "R2 set I");
    step(1, 4'd9, 8'hFF, 16'h0, "R3 mask set all");
    step(1, 4'd8, 8'hFF, 16'h0, "R4 mask clear all under emulation keeps M X");
    step(1, 4'd10, 8'h00, 16'h0, "R5 pull zero under emulation keeps M X");
    step(1, 4'd13, 8'hAB, 16'h0, "R9 X high load ignored while X=1");
    step(1, 4'd12, 8'h00, 16'h1234, "R8 stack transfer in emulation");
    step(0, 4'd9, 8'hFF, 16'h0, "R11 idle holds");
    step(1, 4'd15, 8'hFF, 16'h0, "R11 reserved code holds");
    step(1, 4'd2, 8'h00, 16'h0, "R2 set C before swap");
    step(1, 4'd11, 8'h00, 16'h0, "R6 swap leaves emulation");
    step(1, 4'd8, 8'h30, 16'h0, "R10 widen M and X");
    step(1, 4'd13, 8'hAB, 16'h0, "R9 X high load while X=0");
    step(1, 4'd14, 8'hCD, 16'h0, "R9 Y high load while X=0");
    step(1, 4'd12, 8'h00, 16'hBEEF, "R8 full stack transfer native");
    step(1, 4'd9, 8'h20, 16'h0, "R10 narrow M only");
    step(1, 4'd9, 8'h10, 16'h0, "R9 X set clears high bytes");
    step(1, 4'd8, 8'h10, 16'h0, "R4 clear X native");
    step(1, 4'd14, 8'h5A, 16'h0, "R9 Y high reload");
    step(1, 4'd10, 8'h0F, 16'h0, "R5 pull native keeps high bytes");
    step(1, 4'd10, 8'hD3, 16'h0, "R5 pull sets X clears high bytes");
    step(1, 4'd8, 8'h01, 16'h0, "R4 clear C before swap");
    step(1, 4'd11, 8'h00, 16'h0, "R6 swap with both zero");
    step(1, 4'd8, 8'h30, 16'h0, "R10 widen again");
    step(1, 4'd12, 8'h00, 16'h7788, "R8 native transfer");
    step(1, 4'd13, 8'h99, 16'h0, "R9 load X high");
    step(1, 4'd2, 8'h00, 16'h0, "R2 set C before re-entry");
    step(1, 4'd11, 8'h00, 16'h0, "R7 swap enters emulation and locks");
    step(1, 4'd12, 8'h00, 16'hFFEE, "R8 transfer after re-entry");

    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[9], lfsr[4:1], {lfsr[12:5]}, {lfsr[7:0], lfsr[15:8]},
           "R11 random stream");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule